// File: doc/BRIEF.md
# Debug Session Status Controller

This block follows one on-chip debug session from arming to its end and reports the outcome in a read-only status byte. Software starts a session with an arm strobe and can stop it with a disarm strobe. The session can also end through an internal event. While the session is armed, an external sequencer, driven by comparator matches, proposes its next state. The block records that state in a 3-bit flag field. It also counts trace lines as they are stored and raises a sticky full flag once the trace buffer holds a complete set of lines.

How the state flags look after a session depends on how it ended. A software disarm freezes the last state. An internal end returns the flags to state0. The full flag is the only piece of state that survives a system reset other than power-on. The block exposes two packed views: a status byte and a count view. The count view carries the full flag above the line counter.

Top module: `dbg_session_status`

## Requirements
- R1: A cycle with `arm_set` high and `sys_rst_n` high leaves `armed`=1 and `state_flags`=3'b001 after the next clock edge. The same edge clears the line counter to 0 and `buf_full` to 0. A session that is already armed restarts the same way.
- R2: While `armed` is 1, a cycle with `seq_valid` high loads `seq_state` into `state_flags` at the next edge. This needs no arm, end or disarm strobe in that cycle. A `seq_state` present without `seq_valid` changes nothing.
- R3: While `armed` is 1, `disarm` alone clears `armed` at the next edge and leaves `state_flags` at its last value.
- R4: While `armed` is 1, `end_evt` clears `armed` and sets `state_flags` to 3'b000 at the next edge. When `end_evt` and `disarm` come in the same cycle, `end_evt` wins.
- R5: `arm_set` takes priority over `end_evt`, `disarm` and `seq_valid` in the same cycle. The result is a fresh session in state 3'b001.
- R6: Each cycle with `armed` reading 1 and `trace_push` high adds one to the line counter at the next edge. The counter saturates at 64.
- R7: `buf_full` rises on the same edge at which the counter reaches 64. It then stays at 1 through disarm, end events, further pushes and system resets. Only a new arming or power-on reset clears it.
- R8: `por_n` low clears every register. `sys_rst_n` low for one edge clears `armed`, `state_flags` and the counter, but leaves `buf_full` as it was.
- R9: While `armed` is 0 and there is no arm strobe, `trace_push` and `seq_valid` leave the counter and `state_flags` unchanged.
- R10: `status_byte` has the full flag in bit 7, zeros in bits 6:3 and `state_flags` in bits 2:0. `count_view` has the full flag in bit 7 and the line counter in bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | Other system reset, active low, synchronous |
| arm_set | input | 1 | Software write of one to the arm bit |
| disarm | input | 1 | Software clear of the arm bit |
| end_evt | input | 1 | Internal end-of-session event |
| seq_valid | input | 1 | Sequencer requests a state |
| seq_state | input | 3 | Requested sequencer state |
| trace_push | input | 1 | One trace line stored this cycle |
| armed | output | 1 | Session is armed |
| state_flags | output | 3 | Current sequencer state flags |
| buf_full | output | 1 | Sticky trace-buffer-full flag |
| status_byte | output | 8 | Read-only status view |
| count_view | output | 8 | Full flag above the line counter |

## Verification
The state flags are driven through all eight sequencer codes. Each code is then ended both by a disarm and by an internal event, and the retained value tells the two ending paths apart. A single session is pushed from 0 to 70 lines, with the counter and full flag checked after every line. This shows the exact edge of saturation and of the full flag, and it shows that the counter stops at the limit and does not wrap. Same-cycle collisions of arm, disarm and end separate the priority order. A system reset and a power-on reset applied to a full buffer separate the two reset domains.

// File: rtl/dbg_stat_pkg.sv
`timescale 1ns/1ps
package dbg_stat_pkg;
    localparam int DBG_STATE_W   = 3;
    localparam int DBG_TRACE_LEN = 64;
    localparam int DBG_VIEW_W    = 8;
endpackage

// File: rtl/dbg_session_fsm.sv
`timescale 1ns/1ps
module dbg_session_fsm #(
    parameter int STATE_W = dbg_stat_pkg::DBG_STATE_W
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               sys_rst_n,
    input  logic               arm_set,
    input  logic               disarm,
    input  logic               end_evt,
    input  logic               seq_valid,
    input  logic [STATE_W-1:0] seq_state,
    output logic               armed,
    output logic [STATE_W-1:0] state_flags
);
    localparam logic [STATE_W-1:0] ST_IDLE  = '0;
    localparam logic [STATE_W-1:0] ST_FIRST = STATE_W'(1);

    typedef struct packed {
        logic               armed;
        logic [STATE_W-1:0] state;
    } sess_t;

    sess_t sess_d, sess_q;

    always_comb begin
        sess_d = sess_q;
        if (!sys_rst_n) begin
            sess_d = '0;
        end else if (arm_set) begin
            sess_d.armed = 1'b1;
            sess_d.state = ST_FIRST;
        end else if (sess_q.armed) begin
            if (end_evt) begin
                sess_d.armed = 1'b0;
                sess_d.state = ST_IDLE;
            end else if (disarm) begin
                sess_d.armed = 1'b0;
            end else if (seq_valid && (seq_state != sess_q.state)) begin
                sess_d.state = seq_state;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sess_q <= '0;
        else        sess_q <= sess_d;
    end

    assign armed       = sess_q.armed;
    assign state_flags = sess_q.state;

    assert_arm_start_R1: assert property (@(posedge clk) disable iff (!por_n)
        (arm_set && sys_rst_n) |=> (armed && state_flags == ST_FIRST));

    assert_disarm_keeps_R3: assert property (@(posedge clk) disable iff (!por_n)
        (armed && disarm && !end_evt && !arm_set && sys_rst_n) |=> (!armed && $stable(state_flags)));

    assert_end_clears_R4: assert property (@(posedge clk) disable iff (!por_n)
        (armed && end_evt && !arm_set && sys_rst_n) |=> (!armed && state_flags == ST_IDLE));

    assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!armed && !arm_set && sys_rst_n) |=> $stable(state_flags));
endmodule

// File: rtl/dbg_trace_count.sv
`timescale 1ns/1ps
module dbg_trace_count #(
    parameter int TRACE_LEN = dbg_stat_pkg::DBG_TRACE_LEN,
    parameter int CNT_W     = $clog2(TRACE_LEN + 1)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             arm_set,
    input  logic             armed,
    input  logic             trace_push,
    output logic [CNT_W-1:0] line_cnt,
    output logic             buf_full
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TRACE_LEN);

    typedef struct packed {
        logic             full;
        logic [CNT_W-1:0] cnt;
    } trc_t;

    trc_t trc_d, trc_q;

    always_comb begin
        trc_d = trc_q;
        if (!sys_rst_n) begin
            trc_d.cnt = '0;
        end else if (arm_set) begin
            trc_d = '0;
        end else begin
            if (armed && trace_push && (trc_q.cnt != CNT_MAX))
                trc_d.cnt = trc_q.cnt + 1'b1;
            if (trc_d.cnt == CNT_MAX)
                trc_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) trc_q <= '0;
        else        trc_q <= trc_d;
    end

    assign line_cnt = trc_q.cnt;
    assign buf_full = trc_q.full;

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!por_n)
        line_cnt <= CNT_MAX);

    assert_full_on_limit_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(buf_full) |-> (line_cnt == CNT_MAX));

    assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        (buf_full && !arm_set) |=> buf_full);

    assert_idle_count_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!armed && !arm_set && sys_rst_n) |=> $stable(line_cnt));
endmodule

// File: rtl/dbg_status_view.sv
`timescale 1ns/1ps
module dbg_status_view #(
    parameter int STATE_W = dbg_stat_pkg::DBG_STATE_W,
    parameter int CNT_W   = 7,
    parameter int VIEW_W  = dbg_stat_pkg::DBG_VIEW_W
) (
    input  logic               full,
    input  logic [STATE_W-1:0] state,
    input  logic [CNT_W-1:0]   cnt,
    output logic [VIEW_W-1:0]  status_byte,
    output logic [CNT_W:0]     count_view
);
    localparam int PAD_W = VIEW_W - 1 - STATE_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign status_byte = {full, {PAD_W{1'b0}}, state};
        end else begin : g_nopad
            assign status_byte = {full, state[VIEW_W-2:0]};
        end
    endgenerate

    assign count_view = {full, cnt};
endmodule

// File: rtl/dbg_session_status.sv
`timescale 1ns/1ps
module dbg_session_status #(
    parameter int STATE_W   = dbg_stat_pkg::DBG_STATE_W,
    parameter int TRACE_LEN = dbg_stat_pkg::DBG_TRACE_LEN,
    parameter int VIEW_W    = dbg_stat_pkg::DBG_VIEW_W
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               sys_rst_n,
    input  logic               arm_set,
    input  logic               disarm,
    input  logic               end_evt,
    input  logic               seq_valid,
    input  logic [STATE_W-1:0] seq_state,
    input  logic               trace_push,
    output logic               armed,
    output logic [STATE_W-1:0] state_flags,
    output logic               buf_full,
    output logic [VIEW_W-1:0]  status_byte,
    output logic [VIEW_W-1:0]  count_view
);
    localparam int CNT_W = VIEW_W - 1;

    logic [CNT_W-1:0] line_cnt;

    dbg_session_fsm #(.STATE_W(STATE_W)) u_fsm (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .arm_set(arm_set), .disarm(disarm), .end_evt(end_evt),
        .seq_valid(seq_valid), .seq_state(seq_state),
        .armed(armed), .state_flags(state_flags)
    );

    dbg_trace_count #(.TRACE_LEN(TRACE_LEN), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .arm_set(arm_set), .armed(armed), .trace_push(trace_push),
        .line_cnt(line_cnt), .buf_full(buf_full)
    );

    dbg_status_view #(.STATE_W(STATE_W), .CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_view (
        .full(buf_full), .state(state_flags), .cnt(line_cnt),
        .status_byte(status_byte), .count_view(count_view)
    );

    assert_arm_priority_R5: assert property (@(posedge clk) disable iff (!por_n)
        (arm_set && sys_rst_n) |=> (armed && !buf_full && count_view == '0));

    assert_sysrst_keeps_full_R8: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n) |=> (!armed && state_flags == '0 && buf_full == $past(buf_full)));
endmodule

// File: tb/dbg_session_status_tb.sv
`timescale 1ns/1ps
module dbg_session_status_tb;
    logic       clk = 1'b0;
    logic       por_n, sys_rst_n, arm_set, disarm, end_evt, seq_valid, trace_push;
    logic [2:0] seq_state;
    logic       armed, buf_full;
    logic [2:0] state_flags;
    logic [7:0] status_byte, count_view;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dbg_session_status u_dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_set(arm_set),
        .disarm(disarm), .end_evt(end_evt), .seq_valid(seq_valid),
        .seq_state(seq_state), .trace_push(trace_push), .armed(armed),
        .state_flags(state_flags), .buf_full(buf_full),
        .status_byte(status_byte), .count_view(count_view)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        arm_set = 0; disarm = 0; end_evt = 0; seq_valid = 0; trace_push = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        clr();
    endtask

    task automatic do_arm();  arm_set = 1; tick(); endtask
    task automatic do_seq(input logic [2:0] s); seq_valid = 1; seq_state = s; tick(); endtask
    task automatic do_push(); trace_push = 1; tick(); endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clr(); seq_state = 0; por_n = 0; sys_rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R8 por status", status_byte, 8'h00);
        chk("R8 por count", count_view, 8'h00);
        chk("R8 por armed", armed, 0);
        por_n = 1;
        tick();

        // R9: idle stimulus ignored
        for (int i = 0; i < 5; i++) do_push();
        do_seq(3'd5);
        chk("R9 idle count", count_view, 8'h00);
        chk("R9 idle state", state_flags, 3'd0);

        // R1 / R10
        do_arm();
        chk("R1 armed", armed, 1);
        chk("R1 state", state_flags, 3'd1);
        chk("R10 status", status_byte, 8'h01);

        // R2: sweep all codes
        for (int s = 0; s < 8; s++) begin
            do_seq(3'(s));
            chk("R2 seq load", state_flags, s);
            chk("R10 status low bits", status_byte, s);
        end
        seq_state = 3'd2; tick();
        chk("R2 no valid", state_flags, 3'd7);

        // R3 / R4 from every state
        for (int s = 0; s < 8; s++) begin
            do_arm();
            do_seq(3'(s));
            disarm = 1; tick();
            chk("R3 disarm armed", armed, 0);
            chk("R3 disarm keeps", state_flags, s);
            do_push();
            do_seq(3'(7 - s));
            chk("R9 after disarm state", state_flags, s);
            chk("R9 after disarm count", count_view, 8'h00);
            do_arm();
            do_seq(3'(s));
            end_evt = 1; tick();
            chk("R4 end armed", armed, 0);
            chk("R4 end state", state_flags, 0);
        end
        do_arm(); do_seq(3'd6);
        end_evt = 1; disarm = 1; tick();
        chk("R4 end beats disarm", state_flags, 0);

        // R5: arm priority
        do_arm(); do_seq(3'd5);
        arm_set = 1; end_evt = 1; tick();
        chk("R5 arm vs end armed", armed, 1);
        chk("R5 arm vs end state", state_flags, 3'd1);
        do_seq(3'd4);
        arm_set = 1; disarm = 1; seq_valid = 1; seq_state = 3'd6; tick();
        chk("R5 arm vs disarm", {armed, state_flags}, 4'b1001);

        // R6 / R7 sweep 1..70
        do_arm();
        for (int i = 1; i <= 70; i++) begin
            do_push();
            chk("R6 count", count_view[6:0], (i > 64) ? 64 : i);
            chk("R7 full", buf_full, (i >= 64) ? 1 : 0);
        end
        chk("R10 count view", count_view, 8'hC0);
        chk("R10 status full", status_byte, 8'h81);
        disarm = 1; tick();
        end_evt = 1; tick();
        chk("R7 sticky after disarm", buf_full, 1);

        // R8: system reset keeps full
        do_arm(); do_seq(3'd3);
        for (int i = 0; i < 64; i++) do_push();
        sys_rst_n = 0; tick(); sys_rst_n = 1;
        chk("R8 sysrst count view", count_view, 8'h80);
        chk("R8 sysrst status", status_byte, 8'h80);
        chk("R8 sysrst armed", armed, 0);
        do_arm();
        chk("R7 rearm clears full", count_view, 8'h00);

        // R6 with gaps
        do_push(); tick(); do_push(); tick(); tick(); do_push();
        chk("R6 gapped pushes", count_view, 8'h03);

        // R8: power-on reset clears full
        for (int i = 0; i < 64; i++) do_push();
        chk("R7 full again", buf_full, 1);
        por_n = 0; tick(); por_n = 1; tick();
        chk("R8 por clears full", count_view, 8'h00);
        chk("R8 por clears status", status_byte, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule